// File: doc/BRIEF.md
# Register-Started I2C Master

This block is an I2C bus master that a small processor controls through six 8-bit registers. Software sets a mode byte that holds an enable bit, a clock rate code and a read length. It then writes a slave address byte, and that write launches the whole transaction. The block produces a start condition and shifts out the 7-bit address with the direction bit. It samples the acknowledge. It then either streams bytes that software places in a transmit register, or collects a programmed number of bytes into a receive FIFO. It ends with a stop condition.

Both bus lines are open-drain. The block only ever asserts a pull-low enable for each line and reads the line back. A select input gives the shared pins to an SPI block instead. The bit engine advances on a quarter-bit tick taken from the core clock, so one SCL period lasts 16 × 2^rate core cycles. The block has no stream port. The receive FIFO is drained by reading the receive register, and each read pops one byte. Software must empty the FIFO before it starts a new read, because nothing holds the bus back when the FIFO is full.

Top module: `i2c_reg_master`

## Requirements
- R1: One SCL period lasts 16 << rate core clock cycles, where rate is mode bits 6:5 (codes 0 to 3 give 16, 32, 64 and 128).
- R2: The mode register at offset 0 holds enable in bit 7, rate in bits 6:5 and the receive count in bits 4:0, and it resets to 0. A write to the address register at offset 1 starts a transfer only if enable is 1, the select input is 0 and no transfer is running. Otherwise the write has no effect on the bus.
- R3: A transfer begins with SDA falling while SCL is high. Next comes the byte {address[7:1], rw[0]}, MSB first, with SDA changing only while SCL is low. The transfer ends with SDA rising while SCL is high.
- R4: In a write (bit 0 = 0), the byte written to the transmit register at offset 2 is sent after an acknowledged address. Each acknowledged byte is followed by the next byte only if software has rewritten the transmit register before that acknowledge slot ends; otherwise the stop follows. Taking a byte sets the transmit-empty flag.
- R5: In a read (bit 0 = 1), exactly count+1 bytes (1 to 32) are placed in the FIFO in arrival order. Each read of offset 3 pops one byte. The master acknowledges every byte except the last, which it does not acknowledge.
- R6: If the address is not acknowledged, the NACK flag is set, no data byte is moved, and a stop follows.
- R7: If a written data byte is not acknowledged, the NACK flag is set and the stop follows at once, even when a further byte is waiting.
- R8: While the select input is 1, no transfer starts and neither pull-low enable is asserted.
- R9: The status register at offset 4 has bit 0 done, bit 1 NACK, bit 2 transmit-empty, bit 3 receive-data and bit 4 busy (read-only). Writing 1 to a flag bit clears only that flag. The irq output is the OR of the flags ANDed with the enable mask at offset 5, bits 3:0.
- R10: The done flag sets when the stop condition completes, and busy is 1 from the start of a transfer to that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the FIFO at offset 3) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| spi_sel | input | 1 | 1 gives the shared pins to the SPI block |
| scl_in | input | 1 | SCL line level (unused: no clock stretching) |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| irq | output | 1 | Interrupt request |

## Verification
The assertions rely on several conditions being true of the block's inputs. The slave never stretches SCL. The select input stays fixed for the whole of a transfer. Software empties the receive FIFO before it starts a read, so a push never meets a full FIFO. The bench meets these conditions as follows. Its slave model only answers on SCL edges and only drives SDA while SCL is low. It toggles the select input only while the master is idle. It reads back every received byte before it launches the next transfer.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_ADDR, ST_WR, ST_RD, ST_STOP
  } seq_state_t;

  localparam logic [2:0] OFF_MODE = 3'd0;
  localparam logic [2:0] OFF_SLV  = 3'd1;
  localparam logic [2:0] OFF_TX   = 3'd2;
  localparam logic [2:0] OFF_RX   = 3'd3;
  localparam logic [2:0] OFF_STAT = 3'd4;
  localparam logic [2:0] OFF_IEN  = 3'd5;

  localparam int FLG_DONE = 0;
  localparam int FLG_NACK = 1;
  localparam int FLG_TXE  = 2;
  localparam int FLG_RXA  = 3;
endpackage

// File: rtl/i2cm_qtr_tick.sv
module i2cm_qtr_tick #(
  parameter int RATE_W = 2,
  parameter int BASE   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  localparam int MAXDIV = BASE << ((1 << RATE_W) - 1);
  localparam int CW     = $clog2(MAXDIV) + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  assign limit = CW'((BASE << rate) - 1);
  assign tick  = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt == limit) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  // R1: a quarter lasts at least BASE cycles, so ticks never come back to back
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/i2cm_rx_fifo.sv
module i2cm_rx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  assign empty = (cnt == '0);
  assign full  = (cnt == (AW+1)'(DEPTH));
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push && !full)
        wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop && !empty)
        rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      cnt <= cnt + (AW+1)'(push && !full) - (AW+1)'(pop && !empty);
    end
  end

  // R5: a whole read burst fits, so a push never meets a full FIFO
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
  import i2cm_pkg::*;
#(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       slv_byte,
  input  logic [LEN_W-1:0] rx_len,
  input  logic             tick,
  input  logic [7:0]       tx_data,
  input  logic             tx_full,
  input  logic             sda_in,
  output logic             busy,
  output logic             scl_low,
  output logic             sda_low,
  output logic             tx_take,
  output logic             rx_push,
  output logic [7:0]       rx_data,
  output logic             nack_evt,
  output logic             done_evt
);
  seq_state_t       state;
  logic [1:0]       q;
  logic [3:0]       bitn;
  logic [7:0]       sh;
  logic             rw;
  logic             ackbit;
  logic [LEN_W-1:0] remain;
  logic             data_st, slot_end, ack_end;

  assign busy     = (state != ST_IDLE);
  assign data_st  = (state == ST_ADDR) || (state == ST_WR) || (state == ST_RD);
  assign slot_end = tick && (q == 2'd3);
  assign ack_end  = slot_end && data_st && (bitn == 4'd8);
  assign rx_data  = sh;

  always_comb begin
    tx_take  = ack_end && !ackbit && tx_full &&
               (state == ST_WR || (state == ST_ADDR && !rw));
    nack_evt = ack_end && ackbit && (state == ST_ADDR || state == ST_WR);
    rx_push  = ack_end && (state == ST_RD);
    done_evt = slot_end && (state == ST_STOP);
  end

  // SCL low in quarters 0 and 3 of a bit; SDA moves only at quarter 0
  always_comb begin
    scl_low = 1'b0;
    sda_low = 1'b0;
    unique case (state)
      ST_START: begin scl_low = (q == 2'd3); sda_low = q[1]; end
      ST_ADDR, ST_WR: begin
        scl_low = (q == 2'd0) || (q == 2'd3);
        sda_low = (bitn != 4'd8) && !sh[7];
      end
      ST_RD: begin
        scl_low = (q == 2'd0) || (q == 2'd3);
        sda_low = (bitn == 4'd8) && (remain != LEN_W'(1));
      end
      ST_STOP: begin scl_low = (q == 2'd0); sda_low = !q[1]; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; q <= '0; bitn <= '0; sh <= '0;
      rw <= 1'b0; ackbit <= 1'b1; remain <= '0;
    end else if (state == ST_IDLE) begin
      if (start) begin
        state  <= ST_START;
        q      <= '0;
        bitn   <= '0;
        sh     <= slv_byte;
        rw     <= slv_byte[0];
        remain <= rx_len;
      end
    end else if (tick) begin
      q <= q + 1'b1;
      if (q == 2'd1) begin
        if (bitn == 4'd8)          ackbit <= sda_in;
        else if (state == ST_RD)   sh <= {sh[6:0], sda_in};
      end
      if (q == 2'd3) begin
        unique case (state)
          ST_START: begin state <= ST_ADDR; bitn <= '0; end
          ST_ADDR, ST_WR, ST_RD: begin
            if (bitn != 4'd8) begin
              bitn <= bitn + 1'b1;
              if (state != ST_RD) sh <= {sh[6:0], 1'b0};
            end else begin
              bitn <= '0;
              if (state == ST_RD) begin
                remain <= remain - 1'b1;
                if (remain == LEN_W'(1)) state <= ST_STOP;
              end else if (ackbit) begin
                state <= ST_STOP;
              end else if (state == ST_ADDR && rw) begin
                state <= ST_RD;
              end else if (tx_full) begin
                sh    <= tx_data;
                state <= ST_WR;
              end else begin
                state <= ST_STOP;
              end
            end
          end
          ST_STOP: state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R3: SDA holds while SCL is high inside address and data bits
  p_sda_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_st && (q == 2'd1 || q == 2'd2)) |-> $stable(sda_low));
  // R5: no byte is stored once the programmed count is used up
  p_read_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> (remain != '0));
  // R10: a start request is only acted on from idle
  p_start_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (state == ST_START));
endmodule

// File: rtl/i2c_reg_master.sv
module i2c_reg_master
  import i2cm_pkg::*;
#(
  parameter int RATE_W     = 2,
  parameter int CNT_W      = 5,
  parameter int QTR_BASE   = 4,
  parameter int FIFO_DEPTH = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       spi_sel,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       irq
);
  localparam int LEN_W  = CNT_W + 1;
  localparam int EN_BIT = 7;

  logic [7:0] mode_q, slv_q, tx_q;
  logic [3:0] st, ien;
  logic       tx_full;
  logic       busy, tick, scl_low, sda_low;
  logic       tx_take, rx_push, nack_evt, done_evt;
  logic [7:0] rx_data, fifo_dout;
  logic       fifo_empty, fifo_full;
  logic       wr_mode, wr_slv, wr_tx, wr_stat, wr_ien, rd_rx, start;
  logic [3:0] set_v, clr_v;
  logic       unused_scl;

  assign unused_scl = scl_in;
  assign wr_mode = reg_wr && (reg_addr == OFF_MODE);
  assign wr_slv  = reg_wr && (reg_addr == OFF_SLV);
  assign wr_tx   = reg_wr && (reg_addr == OFF_TX);
  assign wr_stat = reg_wr && (reg_addr == OFF_STAT);
  assign wr_ien  = reg_wr && (reg_addr == OFF_IEN);
  assign rd_rx   = reg_rd && (reg_addr == OFF_RX);
  assign start   = wr_slv && mode_q[EN_BIT] && !spi_sel && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; slv_q <= '0; tx_q <= '0; ien <= '0; tx_full <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= reg_wdata;
      if (wr_slv)  slv_q  <= reg_wdata;
      if (wr_ien)  ien    <= reg_wdata[3:0];
      if (wr_tx) begin
        tx_q    <= reg_wdata;
        tx_full <= 1'b1;
      end else if (tx_take) begin
        tx_full <= 1'b0;
      end
    end
  end

  always_comb begin
    set_v = '0;
    set_v[FLG_DONE] = done_evt;
    set_v[FLG_NACK] = nack_evt;
    set_v[FLG_TXE]  = tx_take;
    set_v[FLG_RXA]  = rx_push;
    clr_v = wr_stat ? reg_wdata[3:0] : 4'b0;
    clr_v[FLG_TXE] = clr_v[FLG_TXE] | wr_tx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= '0;
    else        st <= (st & ~clr_v) | set_v;
  end

  assign irq = |(st & ien);

  always_comb begin
    unique case (reg_addr)
      OFF_MODE: reg_rdata = mode_q;
      OFF_SLV:  reg_rdata = slv_q;
      OFF_TX:   reg_rdata = tx_q;
      OFF_RX:   reg_rdata = fifo_dout;
      OFF_STAT: reg_rdata = {3'b0, busy, st};
      OFF_IEN:  reg_rdata = {4'b0, ien};
      default:  reg_rdata = 8'h00;
    endcase
  end

  i2cm_qtr_tick #(.RATE_W(RATE_W), .BASE(QTR_BASE)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .rate(mode_q[CNT_W +: RATE_W]), .tick(tick));

  i2cm_seq #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .slv_byte(reg_wdata),
    .rx_len(LEN_W'(mode_q[CNT_W-1:0]) + LEN_W'(1)), .tick(tick),
    .tx_data(tx_q), .tx_full(tx_full), .sda_in(sda_in),
    .busy(busy), .scl_low(scl_low), .sda_low(sda_low),
    .tx_take(tx_take), .rx_push(rx_push), .rx_data(rx_data),
    .nack_evt(nack_evt), .done_evt(done_evt));

  i2cm_rx_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_data),
    .pop(rd_rx), .dout(fifo_dout), .empty(fifo_empty), .full(fifo_full));

  assign scl_oe = scl_low && !spi_sel;
  assign sda_oe = sda_low && !spi_sel;

  // R4: a taken byte frees the transmit register unless software refills it
  p_txfull_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_take && !wr_tx) |=> !tx_full);
  // R10: the end of the stop raises the done flag
  p_done_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> st[FLG_DONE]);
  // R6: a missing acknowledge raises the NACK flag
  p_nack_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    nack_evt |=> st[FLG_NACK]);
  // R8: an idle master stays idle while the SPI side owns the pins
  p_spi_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sel && !busy) |=> !busy);
endmodule

// File: tb/tb_i2c_reg_master.sv
module tb_i2c_reg_master;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 190000;
  localparam logic [6:0] SLV = 7'h52;
  // {rate[15:14], rw[13], rct[12:8], wr_n[7:4], bad_addr[3], nack_at[2:0]}
  localparam logic [15:0] VEC [8] = '{
    16'b00_0_00000_0001_0_111,
    16'b01_0_00000_0011_0_111,
    16'b00_1_00000_0000_0_111,
    16'b10_1_00100_0000_0_111,
    16'b00_0_00000_0100_0_001,
    16'b00_1_00011_0000_1_111,
    16'b11_0_00000_0010_0_111,
    16'b00_1_11111_0000_0_111
  };

  logic clk = 0, rst_n = 0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic spi_sel = 0;
  logic scl_oe, sda_oe, irq;
  wire  scl_bus, sda_bus;
  logic s_drv = 0;
  int checks = 0, errors = 0, cyc = 0;

  assign scl_bus = !scl_oe;
  assign sda_bus = !(sda_oe || s_drv);

  i2c_reg_master dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .spi_sel(spi_sel), .scl_in(scl_bus), .sda_in(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > MAX_CYC) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cyc, MAX_CYC);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- slave model ----------------
  logic       s_act = 0, s_isaddr = 0, s_tx = 0, s_rw = 0, s_ack = 0, m_ack = 0;
  logic [7:0] s_sh = '0, addr_seen = '0;
  logic [7:0] wr_log [64];
  logic       mack_log [64];
  int s_bit = 0, wr_cnt = 0, rd_idx = 0, start_cnt = 0, stop_cnt = 0, nack_at = 99;
  logic       bad_addr = 0;
  time t_last = 0, t_prev = 0;

  function automatic logic [7:0] rd_pat(int k); return 8'(k * 37 + 5); endfunction
  function automatic logic [7:0] wr_pat(int k); return 8'(k * 29 + 17); endfunction

  always @(negedge sda_bus) if (scl_bus) begin
    s_act = 1; s_bit = -1; s_isaddr = 1; s_tx = 0; s_drv = 0; start_cnt++;
  end
  always @(posedge sda_bus) if (scl_bus && s_act) begin
    s_act = 0; s_drv = 0; stop_cnt++;
  end
  always @(posedge scl_bus) begin
    t_prev = t_last; t_last = $time;
    if (s_act) begin
      if (s_bit >= 0 && s_bit < 8 && !s_tx) s_sh = {s_sh[6:0], sda_bus};
      if (s_bit == 8 && s_tx) begin m_ack = !sda_bus; mack_log[rd_idx-1] = !sda_bus; end
    end
  end
  always @(negedge scl_bus) if (s_act) begin
    s_bit++;
    if (s_bit == 8) begin
      if (!s_tx) begin
        if (s_isaddr) begin
          addr_seen = s_sh; s_rw = s_sh[0];
          s_ack = (s_sh[7:1] == (bad_addr ? 7'h11 : SLV)) && (s_sh[7:1] == SLV);
        end else begin
          wr_log[wr_cnt] = s_sh; s_ack = (wr_cnt != nack_at); wr_cnt++;
        end
        s_drv = s_ack;
      end else s_drv = 0;
    end else if (s_bit == 9) begin
      s_bit = 0;
      if (s_isaddr) begin s_isaddr = 0; s_tx = s_rw && s_ack; m_ack = 1; end
      if (s_tx && m_ack) begin
        s_sh = rd_pat(rd_idx); rd_idx++; s_drv = !s_sh[7];
      end else begin s_drv = 0; s_tx = 0; end
    end else if (s_tx && s_bit > 0 && s_bit < 8) s_drv = !s_sh[7 - s_bit];
    else s_drv = 0;
  end

  // ---------------- helpers ----------------
  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wait_done();
    logic [7:0] s;
    s = 0;
    while (!s[0]) rd(3'd4, s);
  endtask

  task automatic clear_slave(logic bad, int nat);
    wr_cnt = 0; rd_idx = 0; start_cnt = 0; stop_cnt = 0;
    bad_addr = bad; nack_at = nat;
  endtask

  logic [7:0] d;
  int oe_seen;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state (R2, R9, R8)
    rd(3'd0, d); chk("R2 mode reset", d, 0);
    rd(3'd4, d); chk("R9 status reset", d, 0);
    chk("R8 pins idle at reset", {scl_oe, sda_oe}, 0);
    chk("R9 irq reset", irq, 0);
    wr(3'd0, 8'hE3); rd(3'd0, d); chk("R2 mode readback", d, 8'hE3);

    // vector table
    for (int v = 0; v < 8; v++) begin
      logic [1:0] rate; logic rwv, bad; logic [4:0] rct; int wn, nat, exp_n;
      rate = VEC[v][15:14]; rwv = VEC[v][13]; rct = VEC[v][12:8];
      wn = int'(VEC[v][7:4]); bad = VEC[v][3];
      nat = (VEC[v][2:0] == 3'd7) ? 99 : int'(VEC[v][2:0]);
      clear_slave(bad, nat);
      wr(3'd0, {1'b1, rate, rct});
      if (!rwv) begin
        wr(3'd2, wr_pat(0));
        wr(3'd1, {bad ? 7'h11 : SLV, 1'b0});
        for (int i = 1; i < wn; i++) begin
          d = 0;
          while (!d[2] && !d[0]) rd(3'd4, d);
          if (d[0]) break;
          wr(3'd2, wr_pat(i));
        end
        wait_done();
        exp_n = bad ? 0 : ((nat < wn) ? nat + 1 : wn);
        chk("R4/R7 bytes written", wr_cnt, exp_n);
        for (int i = 0; i < exp_n; i++) chk("R4 byte value", wr_log[i], wr_pat(i));
        rd(3'd4, d); chk("R6/R7 nack flag", d[1], (bad || nat < wn) ? 1 : 0);
      end else begin
        wr(3'd1, {bad ? 7'h11 : SLV, 1'b1});
        wait_done();
        exp_n = bad ? 0 : int'(rct) + 1;
        chk("R5/R6 bytes sent by slave", rd_idx, exp_n);
        rd(3'd4, d);
        chk("R6 nack flag", d[1], bad ? 1 : 0);
        chk("R5 rx data flag", d[3], bad ? 0 : 1);
        for (int i = 0; i < exp_n; i++) begin
          logic [7:0] b;
          rd(3'd3, b);
          chk("R5 fifo byte", b, rd_pat(i));
          chk("R5 master ack", mack_log[i], (i < exp_n - 1) ? 1 : 0);
        end
      end
      chk("R3 address byte", addr_seen, {bad ? 7'h11 : SLV, rwv});
      chk("R3 one start", start_cnt, 1);
      chk("R3 one stop", stop_cnt, 1);
      chk("R1 scl period", int'((t_last - t_prev) / CLK_PERIOD), 16 << rate);
      rd(3'd4, d); chk("R10 done and idle", {d[4], d[0]}, 2'b01);
      wr(3'd4, 8'h0F); rd(3'd4, d); chk("R9 w1c all", d, 0);
    end

    // R2: start ignored while disabled
    clear_slave(0, 99);
    wr(3'd0, 8'h00); wr(3'd1, {SLV, 1'b0});
    repeat (300) @(negedge clk);
    chk("R2 disabled no start", start_cnt, 0);
    rd(3'd4, d); chk("R2 disabled not busy", d[4], 0);

    // R8: SPI owns the pins
    wr(3'd0, 8'h80); spi_sel = 1; oe_seen = 0;
    wr(3'd1, {SLV, 1'b0});
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); if (scl_oe || sda_oe) oe_seen++;
    end
    chk("R8 no drive while spi", oe_seen, 0);
    chk("R8 no start while spi", start_cnt, 0);
    spi_sel = 0;

    // R2: second address write during a transfer is ignored
    clear_slave(0, 99);
    wr(3'd2, 8'h3C); wr(3'd1, {SLV, 1'b0}); wr(3'd1, {7'h11, 1'b1});
    wait_done();
    chk("R2 busy start ignored", start_cnt, 1);
    chk("R2 first address kept", addr_seen, {SLV, 1'b0});
    chk("R4 single byte", wr_cnt, 1);
    wr(3'd4, 8'h0F);

    // R9: selective clear and irq masking
    clear_slave(1, 99);
    wr(3'd1, {7'h11, 1'b0});
    wait_done();
    chk("R9 irq masked", irq, 0);
    wr(3'd5, 8'h01); @(negedge clk); chk("R9 irq on done", irq, 1);
    wr(3'd4, 8'h01); rd(3'd4, d); chk("R9 w1c one flag", d, 8'h02);
    chk("R9 irq after clear", irq, 0);
    wr(3'd5, 8'h02); @(negedge clk); chk("R9 irq on nack", irq, 1);
    wr(3'd4, 8'h02); @(negedge clk); chk("R9 irq cleared", irq, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule